// File: doc/BRIEF.md
# IDE Bus-Master DMA Launch Controller

This block is the launch and completion engine for bus-master DMA on a two-channel IDE host adapter. For each channel, the host first writes a 32-bit command word. That word holds the descriptor table address in its upper bits and a direction code in bits 1:0. The host then writes a transfer count, and that single write arms the transfer. There is no separate start bit. A simulated disk side reports each 16-bit word it moves on a per-channel strobe. The host polls a status register that shows the remaining word count while the transfer runs. When the transfer ends, the register settles on a fixed code.

Each channel also holds an 8-bit general configuration register. DMA can start only when both its DMA-enable bit and its bus-master bit are set. Otherwise the channel stays in programmed-I/O mode and ignores count writes. The two channels have identical register sets. The secondary set sits at the primary offsets with address bit 7 set. A busmaster interrupt flag per channel rises when a transfer ends and falls when the host reads that channel's status.

Top module: `ide_bm_dma`

## Requirements
- R1: After reset both channels are idle. Status reads 0x00000000, and `xfer_busy`, `bm_irq` and `dma_mode` are all 0.
- R2: A write to the command offset (0x00) stores the full 32-bit word, and a read of that offset returns it. When a transfer starts, `table_addr` shows the word with bits 1:0 cleared. At the same point, `xfer_to_drive` is 1 for direction code 1 (toward the drive) and 0 for code 2 (from the drive).
- R3: A write to the count offset (0x04) on an enabled, idle channel with a valid direction starts the transfer. `xfer_busy` is 1 in the cycle after the write. Status then reads the written value plus one, which is the number of 16-bit words to move.
- R4: While busy, each cycle with `word_done` high lowers the status value by exactly one.
- R5: When the last word is moved, `xfer_busy` drops in the next cycle and status reads exactly 0x000000FF.
- R6: `bm_irq` rises in the cycle in which a transfer ends. A status read of that channel clears it, and the flag is 0 in the cycle after the read.
- R7: A count write while the channel is busy is ignored. The remaining count and the busy state do not change.
- R8: `dma_mode` is 1 only when configuration bit 7 (DMA enable) and bit 1 (bus master) are both set. The configuration register is at offset 0x08. A count write while `dma_mode` is 0 is ignored, and status keeps its previous value.
- R9: The secondary channel's registers are at the primary offsets XOR 0x80. Its transfers, status and flags are independent of the primary channel's.
- R10: A count write on an enabled channel whose direction code is 0 or 3 ends at once without busy. Status then reads 0x0000FF00 and `bm_irq` rises.
- R11: `word_done` on a channel that is not busy has no effect on that channel's status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe |
| host_addr | input | ADDR_W | Host register address; the top bit selects the channel |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Read data, registered, valid the cycle after `host_rd` |
| word_done | input | 2 | Per channel, one 16-bit word moved by the disk side |
| xfer_busy | output | 2 | Per channel, transfer in progress |
| xfer_to_drive | output | 2 | Per channel, latched direction: 1 means toward the drive |
| dma_mode | output | 2 | Per channel, DMA permitted by the configuration |
| bm_irq | output | 2 | Per channel, busmaster interrupt flag |
| table_addr | output | 2*DATA_W | Per channel, latched descriptor table address |

## Verification
Every result of this block is due one clock edge after its stimulus:
- a count write shows as `xfer_busy` and the new status,
- a `word_done` strobe shows as a lower status,
- the last strobe shows as the 0xFF code and `bm_irq`,
- a status read shows on `host_rdata` and as a cleared flag.

The bench drives each stimulus at a falling edge and holds it for one full cycle. It then checks flags and status at the next falling edge. Read data is compared one time unit after the rising edge that registers it. The scoreboard monitor pops expected read values only on cycles in which a read was issued. That way, a late or missing read result shows up as a mismatch, never as a stale value that happens to match.

// File: rtl/ide_bm_pkg.sv
package ide_bm_pkg;
  // two channels: the channel is picked by the top address bit
  localparam int NUM_CH = 2;

  // register offsets inside one channel window
  localparam int OFS_CMD = 'h00;
  localparam int OFS_CNT = 'h04; // write: count, read: status
  localparam int OFS_CFG = 'h08;

  // configuration bits that together permit DMA
  localparam int CFG_DMA_EN_BIT = 7;
  localparam int CFG_BM_BIT     = 1;

  localparam logic [1:0] DIR_TO_DRIVE   = 2'd1;
  localparam logic [1:0] DIR_FROM_DRIVE = 2'd2;

  localparam logic [15:0] STAT_OK  = 16'h00FF;
  localparam logic [15:0] STAT_ERR = 16'hFF00;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_BUSY,
    ENG_DONE,
    ENG_FAULT
  } eng_state_e;
endpackage

// File: rtl/ide_bm_decode.sv
module ide_bm_decode
  import ide_bm_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                host_wr,
  input  logic                host_rd,
  input  logic [ADDR_W-1:0]   host_addr,
  output logic [NUM_CH-1:0]   wr_cmd,
  output logic [NUM_CH-1:0]   wr_cnt,
  output logic [NUM_CH-1:0]   wr_cfg,
  output logic [NUM_CH-1:0]   rd_stat
);
  localparam int OW = ADDR_W - 1;

  logic [OW-1:0] ofs;
  assign ofs = host_addr[OW-1:0];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic hit;
    assign hit        = (host_addr[ADDR_W-1] == 1'(ch));
    assign wr_cmd[ch]  = host_wr && hit && (ofs == OW'(OFS_CMD));
    assign wr_cnt[ch]  = host_wr && hit && (ofs == OW'(OFS_CNT));
    assign wr_cfg[ch]  = host_wr && hit && (ofs == OW'(OFS_CFG));
    assign rd_stat[ch] = host_rd && hit && (ofs == OW'(OFS_CNT));
  end
endmodule

// File: rtl/ide_bm_chan.sv
module ide_bm_chan
  import ide_bm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_cmd,
  input  logic              wr_cnt,
  input  logic              wr_cfg,
  input  logic              rd_stat,
  input  logic [DATA_W-1:0] wdata,
  input  logic              word_done,
  output logic [DATA_W-1:0] cmd_q,
  output logic [7:0]        cfg_q,
  output logic [DATA_W-1:0] status,
  output logic              busy,
  output logic              to_drive,
  output logic              dma_ok,
  output logic              irq,
  output logic [DATA_W-1:0] table_addr
);
  localparam int REM_W = CNT_W + 1;

  eng_state_e        state_q;
  logic [REM_W-1:0]  rem_q;
  logic              dir_q;
  logic [DATA_W-1:0] tbl_q;
  logic              dir_valid;
  logic              finish_ok;
  logic              finish_err;

  assign dma_ok    = cfg_q[CFG_DMA_EN_BIT] && cfg_q[CFG_BM_BIT];
  assign dir_valid = (cmd_q[1:0] == DIR_TO_DRIVE) || (cmd_q[1:0] == DIR_FROM_DRIVE);
  assign finish_ok = (state_q == ENG_BUSY) && word_done && (rem_q == REM_W'(1));
  assign finish_err = (state_q != ENG_BUSY) && wr_cnt && dma_ok && !dir_valid;

  // configuration and command registers
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
      cfg_q <= '0;
    end else begin
      if (wr_cmd) cmd_q <= wdata;
      if (wr_cfg) cfg_q <= wdata[7:0];
    end
  end

  // launch / count / completion engine
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ENG_IDLE;
      rem_q   <= '0;
      dir_q   <= 1'b0;
      tbl_q   <= '0;
    end else begin
      case (state_q)
        ENG_BUSY: begin
          if (word_done) begin
            if (rem_q == REM_W'(1)) state_q <= ENG_DONE;
            rem_q <= rem_q - REM_W'(1);
          end
        end
        default: begin
          if (wr_cnt && dma_ok) begin
            if (dir_valid) begin
              state_q <= ENG_BUSY;
              rem_q   <= {1'b0, wdata[CNT_W-1:0]} + REM_W'(1);
              dir_q   <= (cmd_q[1:0] == DIR_TO_DRIVE);
              tbl_q   <= {cmd_q[DATA_W-1:2], 2'b00};
            end else begin
              state_q <= ENG_FAULT;
            end
          end
        end
      endcase
    end
  end

  // busmaster interrupt flag: completion wins over a same-cycle read
  always_ff @(posedge clk) begin
    if (rst)                      irq <= 1'b0;
    else if (finish_ok || finish_err) irq <= 1'b1;
    else if (rd_stat)             irq <= 1'b0;
  end

  always_comb begin
    case (state_q)
      ENG_BUSY:  status = DATA_W'(rem_q);
      ENG_DONE:  status = DATA_W'(STAT_OK);
      ENG_FAULT: status = DATA_W'(STAT_ERR);
      default:   status = '0;
    endcase
  end

  assign busy       = (state_q == ENG_BUSY);
  assign to_drive   = dir_q;
  assign table_addr = tbl_q;
endmodule

// File: rtl/ide_bm_rdmux.sv
module ide_bm_rdmux
  import ide_bm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           host_rd,
  input  logic [ADDR_W-1:0]              host_addr,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  cmd_all,
  input  logic [NUM_CH-1:0][7:0]         cfg_all,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  stat_all,
  output logic [DATA_W-1:0]              rdata
);
  localparam int OW = ADDR_W - 1;

  logic              ch;
  logic [OW-1:0]     ofs;
  logic [DATA_W-1:0] sel;

  assign ch  = host_addr[ADDR_W-1];
  assign ofs = host_addr[OW-1:0];

  always_comb begin
    if (ofs == OW'(OFS_CMD))      sel = cmd_all[ch];
    else if (ofs == OW'(OFS_CNT)) sel = stat_all[ch];
    else if (ofs == OW'(OFS_CFG)) sel = DATA_W'(cfg_all[ch]);
    else                          sel = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata <= '0;
    else if (host_rd) rdata <= sel;
  end
endmodule

// File: rtl/ide_bm_dma.sv
module ide_bm_dma
  import ide_bm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     host_wr,
  input  logic                     host_rd,
  input  logic [ADDR_W-1:0]        host_addr,
  input  logic [DATA_W-1:0]        host_wdata,
  output logic [DATA_W-1:0]        host_rdata,
  input  logic [1:0]               word_done,
  output logic [1:0]               xfer_busy,
  output logic [1:0]               xfer_to_drive,
  output logic [1:0]               dma_mode,
  output logic [1:0]               bm_irq,
  output logic [2*DATA_W-1:0]      table_addr
);
  logic [NUM_CH-1:0] wr_cmd, wr_cnt, wr_cfg, rd_stat;
  logic [NUM_CH-1:0][DATA_W-1:0] cmd_all;
  logic [NUM_CH-1:0][7:0]        cfg_all;
  logic [NUM_CH-1:0][DATA_W-1:0] stat_all;

  ide_bm_decode #(.ADDR_W(ADDR_W)) u_dec (
    .host_wr  (host_wr),
    .host_rd  (host_rd),
    .host_addr(host_addr),
    .wr_cmd   (wr_cmd),
    .wr_cnt   (wr_cnt),
    .wr_cfg   (wr_cfg),
    .rd_stat  (rd_stat)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    ide_bm_chan #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .wr_cmd    (wr_cmd[ch]),
      .wr_cnt    (wr_cnt[ch]),
      .wr_cfg    (wr_cfg[ch]),
      .rd_stat   (rd_stat[ch]),
      .wdata     (host_wdata),
      .word_done (word_done[ch]),
      .cmd_q     (cmd_all[ch]),
      .cfg_q     (cfg_all[ch]),
      .status    (stat_all[ch]),
      .busy      (xfer_busy[ch]),
      .to_drive  (xfer_to_drive[ch]),
      .dma_ok    (dma_mode[ch]),
      .irq       (bm_irq[ch]),
      .table_addr(table_addr[ch*DATA_W +: DATA_W])
    );
  end

  ide_bm_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .host_rd  (host_rd),
    .host_addr(host_addr),
    .cmd_all  (cmd_all),
    .cfg_all  (cfg_all),
    .stat_all (stat_all),
    .rdata    (host_rdata)
  );
endmodule

// File: rtl/ide_bm_dma_chk.sv
module ide_bm_dma_chk
  import ide_bm_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              host_wr,
  input logic              host_rd,
  input logic [ADDR_W-1:0] host_addr,
  input logic [1:0]        word_done,
  input logic [1:0]        xfer_busy,
  input logic [1:0]        dma_mode,
  input logic [1:0]        bm_irq
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
    localparam logic [ADDR_W-1:0] CNT_A =
      ADDR_W'(OFS_CNT) | (ch == 1 ? ADDR_W'(1) << (ADDR_W-1) : '0);

    // R3
    start_needs_cnt_wr_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(xfer_busy[ch]) |-> $past(host_wr && host_addr == CNT_A));

    // R5
    end_needs_word_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(xfer_busy[ch]) |-> $past(word_done[ch]));

    // R6
    irq_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(bm_irq[ch]) |-> ($fell(xfer_busy[ch]) || $past(host_wr && host_addr == CNT_A)));

    // R6
    irq_read_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (bm_irq[ch] && host_rd && !host_wr && host_addr == CNT_A && !xfer_busy[ch])
        |=> !bm_irq[ch]);

    // R8
    no_start_in_pio_chk: assert property (@(posedge clk) disable iff (rst)
      (!dma_mode[ch] && !xfer_busy[ch]) |=> !xfer_busy[ch]);

    // R7
    busy_holds_chk: assert property (@(posedge clk) disable iff (rst)
      (xfer_busy[ch] && !word_done[ch]) |=> xfer_busy[ch]);
  end
endmodule

bind ide_bm_dma ide_bm_dma_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .host_wr  (host_wr),
  .host_rd  (host_rd),
  .host_addr(host_addr),
  .word_done(word_done),
  .xfer_busy(xfer_busy),
  .dma_mode (dma_mode),
  .bm_irq   (bm_irq)
);

// File: tb/ide_bm_dma_tb.sv
module ide_bm_dma_tb;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_wr = 1'b0, host_rd = 1'b0;
  logic [ADDR_W-1:0] host_addr = '0;
  logic [DATA_W-1:0] host_wdata = '0;
  logic [DATA_W-1:0] host_rdata;
  logic [1:0] word_done = '0;
  logic [1:0] xfer_busy, xfer_to_drive, dma_mode, bm_irq;
  logic [2*DATA_W-1:0] table_addr;

  int n_chk = 0;
  int n_fail = 0;
  logic [DATA_W-1:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk; // 125 MHz

  ide_bm_dma u_dut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .word_done(word_done), .xfer_busy(xfer_busy), .xfer_to_drive(xfer_to_drive),
    .dma_mode(dma_mode), .bm_irq(bm_irq), .table_addr(table_addr)
  );

  localparam logic [7:0] A_CMD0 = 8'h00, A_CNT0 = 8'h04, A_CFG0 = 8'h08;
  localparam logic [7:0] A_CMD1 = 8'h80, A_CNT1 = 8'h84, A_CFG1 = 8'h88;

  task automatic check(input bit ok, input string tag, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  // driver: issue a read and push the expected value for the monitor
  task automatic rd_exp(input logic [7:0] a, input logic [DATA_W-1:0] e, input string tag);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic words(input int ch, input int n);
    @(negedge clk);
    word_done[ch] = 1'b1;
    repeat (n - 1) @(negedge clk);
    @(negedge clk);
    word_done[ch] = 1'b0;
  endtask

  // monitor: read data registered at the edge that samples host_rd
  always @(posedge clk) begin
    if (host_rd && !rst) begin
      #1;
      if (exp_q.size() == 0) begin
        check(1'b0, "unexpected read", host_rdata, '0);
      end else begin
        automatic logic [DATA_W-1:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(host_rdata == e, t, host_rdata, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", '0, '0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(xfer_busy == 2'b00, "R1 busy", 32'(xfer_busy), 0);
    check(bm_irq == 2'b00, "R1 irq", 32'(bm_irq), 0);
    check(dma_mode == 2'b00, "R1 dma_mode", 32'(dma_mode), 0);
    rd_exp(A_CNT0, 32'h0, "R1 status ch0");
    rd_exp(A_CNT1, 32'h0, "R1 status ch1");

    // R2 command register readback
    wr(A_CMD0, 32'h0000_1001);
    rd_exp(A_CMD0, 32'h0000_1001, "R2 cmd readback");

    // R8 no start without both enable bits
    wr(A_CNT0, 32'd3);
    check(xfer_busy[0] == 1'b0, "R8 cfg=0 no start", 32'(xfer_busy[0]), 0);
    wr(A_CFG0, 32'h80);
    check(dma_mode[0] == 1'b0, "R8 dma_mode bit7 only", 32'(dma_mode[0]), 0);
    wr(A_CNT0, 32'd3);
    check(xfer_busy[0] == 1'b0, "R8 bit7 only no start", 32'(xfer_busy[0]), 0);
    wr(A_CFG0, 32'h02);
    wr(A_CNT0, 32'd3);
    check(xfer_busy[0] == 1'b0, "R8 bit1 only no start", 32'(xfer_busy[0]), 0);
    rd_exp(A_CNT0, 32'h0, "R8 status unchanged");
    wr(A_CFG0, 32'h82);
    check(dma_mode[0] == 1'b1, "R8 dma_mode both bits", 32'(dma_mode[0]), 1);
    rd_exp(A_CFG0, 32'h82, "R8 cfg readback");

    // R3 start
    wr(A_CNT0, 32'd3);
    check(xfer_busy[0] == 1'b1, "R3 busy after count", 32'(xfer_busy[0]), 1);
    check(xfer_to_drive[0] == 1'b1, "R2 to_drive dir1", 32'(xfer_to_drive[0]), 1);
    check(table_addr[31:0] == 32'h1000, "R2 table_addr", table_addr[31:0], 32'h1000);
    rd_exp(A_CNT0, 32'd4, "R3 status words");

    // R7 count write while busy
    wr(A_CNT0, 32'd9);
    rd_exp(A_CNT0, 32'd4, "R7 ignored while busy");

    // R4 decrement, R11 idle channel unaffected
    words(0, 1);
    rd_exp(A_CNT0, 32'd3, "R4 one word");
    words(1, 2);
    rd_exp(A_CNT1, 32'd0, "R11 idle ch1 word_done");

    // R5 completion, R6 irq
    words(0, 2);
    check(xfer_busy[0] == 1'b1, "R4 still busy", 32'(xfer_busy[0]), 1);
    check(bm_irq[0] == 1'b0, "R6 no irq yet", 32'(bm_irq[0]), 0);
    words(0, 1);
    check(xfer_busy[0] == 1'b0, "R5 busy dropped", 32'(xfer_busy[0]), 0);
    check(bm_irq[0] == 1'b1, "R6 irq set", 32'(bm_irq[0]), 1);
    rd_exp(A_CNT0, 32'h0000_00FF, "R5 ok code");
    check(bm_irq[0] == 1'b0, "R6 irq cleared by read", 32'(bm_irq[0]), 0);

    // R9 secondary channel, read from drive
    wr(A_CMD1, 32'h0000_2002);
    wr(A_CFG1, 32'h82);
    wr(A_CNT1, 32'd0);
    check(xfer_busy == 2'b10, "R9 ch1 busy only", 32'(xfer_busy), 2);
    check(xfer_to_drive[1] == 1'b0, "R2 to_drive dir2", 32'(xfer_to_drive[1]), 0);
    check(table_addr[63:32] == 32'h2000, "R9 ch1 table_addr", table_addr[63:32], 32'h2000);
    rd_exp(A_CNT1, 32'd1, "R9 ch1 status");
    rd_exp(A_CNT0, 32'hFF, "R9 ch0 untouched");
    words(1, 1);
    check(bm_irq == 2'b10, "R9 ch1 irq only", 32'(bm_irq), 2);
    rd_exp(A_CNT1, 32'hFF, "R9 ch1 done");

    // R10 invalid direction
    wr(A_CMD0, 32'h0000_3003);
    wr(A_CNT0, 32'd5);
    check(xfer_busy[0] == 1'b0, "R10 no busy", 32'(xfer_busy[0]), 0);
    check(bm_irq[0] == 1'b1, "R10 irq", 32'(bm_irq[0]), 1);
    rd_exp(A_CNT0, 32'h0000_FF00, "R10 error code");

    // R4/R5 back-to-back words
    wr(A_CMD0, 32'h0000_4002);
    wr(A_CNT0, 32'd7);
    rd_exp(A_CNT0, 32'd8, "R3 count 7");
    words(0, 5);
    rd_exp(A_CNT0, 32'd3, "R4 five words");
    words(0, 3);
    check(xfer_busy[0] == 1'b0, "R5 back-to-back end", 32'(xfer_busy[0]), 0);
    rd_exp(A_CNT0, 32'hFF, "R5 back-to-back ok");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) check(1'b0, "scoreboard drained", 32'(exp_q.size()), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule